// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

This block adds two unsigned WIDTH-bit operands one bit position per clock. A single handshake captures both operands into two shift registers. Each cycle the registers present their lowest bit pair to a carry state machine. The machine's sum bit is shifted into a result register from the top, so after the last step the result register holds the sum with the first bit formed at bit 0. A completion flag then rises and a carry-out flag shows the final carry. Both stay frozen until the next operand pair is accepted.

The carry state machine comes in two forms, chosen by the parameter `MOORE`. The Mealy form keeps the carry as its only state bit and forms the sum bit combinationally from the state and the current bit pair. The Moore form has four states, each holding both a carry and a sum bit, and its output depends only on the state. Because its sum bit appears one cycle after the bit pair that produced it, a Moore build runs one extra shift cycle.

The operand input is a valid/ready stream. A pair is taken on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` is low for the whole time an addition is in progress. A source that holds `op_valid` during that time is back-pressured: its data stays unconsumed and has no effect. `op_ready` returns high on the same edge that `sum_done` rises. The result pins are plain status outputs.

Top module: `serial_adder_top`

## Requirements
- R1: After reset `op_ready` is high. An edge with `op_valid` and `op_ready` both high captures `op_a` and `op_b` and clears the carry state to 0.
- R2: While an addition is running `op_ready` is low, and `op_valid` with any operand values changes neither the running addition nor its result.
- R3: The Mealy carry state goes from 0 to 1 on bit pair 11, goes from 1 to 0 on bit pair 00, and otherwise keeps its value. The sum bit is the XOR of both bits and the carry.
- R4: When `sum_done` is high, `sum_q` equals (a + b) mod 2^WIDTH and `sum_cout` equals bit WIDTH of a + b, in both forms.
- R5: `sum_done` rises exactly WIDTH clock edges after the accepting edge in the Mealy form and WIDTH+1 edges after it in the Moore form, and is low in between.
- R6: Once high, `sum_done`, `sum_q` and `sum_cout` hold their values until the next accepted operand pair.
- R7: The Moore states use the encodings 00 = carry 0 sum 0, 01 = carry 0 sum 1, 10 = carry 1 sum 0 and 11 = carry 1 sum 1 (bit 1 is the carry, bit 0 is the sum). The sum bit shifted into the result is taken from the state register alone.
- R8: Reset clears `sum_done`, `sum_q` and `sum_cout` to 0.
- R9: A new pair accepted while `sum_done` is high starts a fresh addition, and `sum_done` is low one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operand pair offered |
| op_ready | output | 1 | Block can take an operand pair |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum_q | output | WIDTH | Parallel sum, valid while `sum_done` is high |
| sum_cout | output | 1 | Final carry, valid while `sum_done` is high |
| sum_done | output | 1 | Addition complete |

## Verification
Results are due a fixed number of edges after the accepting edge: WIDTH edges for a Mealy build and WIDTH+1 for a Moore build. The bench drives one Mealy and one Moore instance with the same stimulus. It counts falling edges from the handshake and checks at every one of them that each completion flag is low before its due edge and high from that edge on. The sum and carry are compared only after that point. A few idle cycles after completion confirm the values are held, and extra offers are made mid-run to confirm that back-pressure leaves the result unchanged.

// File: rtl/sa_pkg.sv
package sa_pkg;

  // Mealy form: the state is the carry
  typedef enum logic {
    CY_LO = 1'b0,
    CY_HI = 1'b1
  } mealy_st_t;

  // Moore form: bit 1 carry, bit 0 sum
  typedef enum logic [1:0] {
    ST_C0S0 = 2'b00,
    ST_C0S1 = 2'b01,
    ST_C1S0 = 2'b10,
    ST_C1S1 = 2'b11
  } moore_st_t;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] pdata,
  input  logic             sin,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= pdata;
    end else if (shift) begin
      q <= {sin, q[WIDTH-1:1]};
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(pdata)); // R1

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> q == {$past(sin), $past(q[WIDTH-1:1])}); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !load) |=> $stable(q)); // R6

endmodule

// File: rtl/sa_carry_core.sv
module sa_carry_core
  import sa_pkg::*;
#(
  parameter bit MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic x,
  input  logic y,
  output logic sum_bit,
  output logic carry
);

  generate
    if (MOORE) begin : g_moore
      moore_st_t st_q, st_d;

      always_comb begin
        st_d = st_q;
        if (step) begin
          st_d = moore_st_t'({fa_carry(x, y, st_q[1]), fa_sum(x, y, st_q[1])});
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q <= ST_C0S0;
        end else if (clear) begin
          st_q <= ST_C0S0;
        end else begin
          st_q <= st_d;
        end
      end

      assign sum_bit = st_q[0];
      assign carry   = st_q[1];

      AST_MOORE_SUM_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> sum_bit == ($past(x) ^ $past(y) ^ $past(carry))); // R7

      AST_MOORE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> carry == (($past(x) & $past(y)) |
                                       ($past(carry) & ($past(x) | $past(y))))); // R7

      AST_MOORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!carry && !sum_bit)); // R1

    end else begin : g_mealy
      mealy_st_t st_q, st_d;

      always_comb begin
        st_d = st_q;
        if (step) begin
          unique case (st_q)
            CY_LO: if (x && y)   st_d = CY_HI;
            CY_HI: if (!x && !y) st_d = CY_LO;
            default: st_d = CY_LO;
          endcase
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q <= CY_LO;
        end else if (clear) begin
          st_q <= CY_LO;
        end else begin
          st_q <= st_d;
        end
      end

      assign carry   = st_q;
      assign sum_bit = fa_sum(x, y, st_q);

      AST_MEALY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !carry && x && y) |=> carry); // R3

      AST_MEALY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && carry && !x && !y) |=> !carry); // R3

      AST_MEALY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && (x ^ y)) |=> $stable(carry)); // R3

      AST_MEALY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !carry); // R1
    end
  endgenerate

  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(carry)); // R6

endmodule

// File: rtl/sa_seq.sv
module sa_seq #(
  parameter int WIDTH = 8,
  parameter int LAG   = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy,
  output logic done,
  output logic fsm_step
);

  localparam int CYCLES = WIDTH + LAG;
  localparam int CW     = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST  = CW'(CYCLES - 1);
  localparam logic [CW-1:0] NSTEP = CW'(WIDTH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (accept) begin
      cnt_q <= '0;
      busy  <= 1'b1;
      done  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign fsm_step = busy && (cnt_q < NSTEP);

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept); // R2

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> done); // R6

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!done && busy)); // R9

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q <= LAST); // R5

endmodule

// File: rtl/serial_adder_top.sv
module serial_adder_top #(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum_q,
  output logic             sum_cout,
  output logic             sum_done
);

  localparam int LAG = MOORE ? 1 : 0;

  logic             accept;
  logic             busy;
  logic             fsm_step;
  logic             sbit;
  logic [WIDTH-1:0] opa_q;
  logic [WIDTH-1:0] opb_q;

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready;

  sa_seq #(.WIDTH(WIDTH), .LAG(LAG)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .busy     (busy),
    .done     (sum_done),
    .fsm_step (fsm_step)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_opa (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .shift (busy),
    .pdata (op_a),
    .sin   (1'b0),
    .q     (opa_q)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_opb (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .shift (busy),
    .pdata (op_b),
    .sin   (1'b0),
    .q     (opb_q)
  );

  sa_carry_core #(.MOORE(MOORE)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .step    (fsm_step),
    .x       (opa_q[0]),
    .y       (opb_q[0]),
    .sum_bit (sbit),
    .carry   (sum_cout)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (1'b0),
    .shift (busy),
    .pdata ('0),
    .sin   (sbit),
    .q     (sum_q)
  );

  AST_OPERANDS_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    sum_done |-> (opa_q == '0 && opb_q == '0)); // R4

  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_done && !op_valid) |=> ($stable(sum_q) && $stable(sum_cout))); // R6

  AST_READY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    sum_done |-> op_ready); // R9

endmodule

// File: tb/serial_adder_top_test.sv
module serial_adder_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 8;
  localparam logic [2*W-1:0] VEC [NVEC] = '{
    16'h0000, 16'hFF01, 16'hFFFF, 16'h55AA,
    16'h8080, 16'h0F01, 16'h7F7F, 16'hA55A
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic rdy_m, rdy_o, done_m, done_o, cout_m, cout_o;
  logic [W-1:0] sum_m, sum_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_adder_top #(.WIDTH(W), .MOORE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(rdy_m),
    .op_a(op_a), .op_b(op_b), .sum_q(sum_m), .sum_cout(cout_m), .sum_done(done_m)
  );

  serial_adder_top #(.WIDTH(W), .MOORE(1'b1)) uut_moore (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(rdy_o),
    .op_a(op_a), .op_b(op_b), .sum_q(sum_o), .sum_cout(cout_o), .sum_done(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      summary();
    end
  end

  // Offer a pair at a falling edge; it is taken on the next rising edge.
  // The k-th falling edge afterwards has seen k-1 edges since acceptance.
  task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input bit inject);
    logic [W:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    chk(rdy_m && rdy_o, "R1 ready before offer", {rdy_m, rdy_o}, 2'b11);
    op_a = a;
    op_b = b;
    op_valid = 1'b1;
    for (int k = 1; k <= W + 2; k++) begin
      @(negedge clk);
      if (k == 1) op_valid = 1'b0;
      if (inject && k == 3) begin
        op_a = ~a;
        op_b = a;
        op_valid = 1'b1;
      end
      if (inject && k == 4) op_valid = 1'b0;
      chk(done_m == ((k - 1) >= W), "R5 R9 mealy done timing", done_m, ((k - 1) >= W));
      chk(done_o == ((k - 1) >= W + 1), "R5 R9 moore done timing", done_o, ((k - 1) >= W + 1));
      if (k == 2) chk(!rdy_m && !rdy_o, "R2 ready low while busy", {rdy_m, rdy_o}, 2'b00);
    end
    chk(sum_m == exp[W-1:0], "R4 R3 mealy sum", sum_m, exp[W-1:0]);
    chk(cout_m == exp[W], "R4 R3 mealy carry", cout_m, exp[W]);
    chk(sum_o == exp[W-1:0], "R4 R7 moore sum", sum_o, exp[W-1:0]);
    chk(cout_o == exp[W], "R4 R7 moore carry", cout_o, exp[W]);
    if (inject) begin
      chk(sum_m == exp[W-1:0] && sum_o == exp[W-1:0], "R2 offer while busy ignored",
          {sum_m, sum_o}, {exp[W-1:0], exp[W-1:0]});
    end
  endtask

  initial begin
    logic [W:0] last;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!done_m && !done_o, "R8 done after reset", {done_m, done_o}, 2'b00);
    chk(sum_m == '0 && sum_o == '0, "R8 sum after reset", {sum_m, sum_o}, '0);
    chk(!cout_m && !cout_o, "R8 carry after reset", {cout_m, cout_o}, 2'b00);
    chk(rdy_m && rdy_o, "R1 ready after reset", {rdy_m, rdy_o}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_add(VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0);
    end

    // R2: offers during a running addition are back-pressured
    run_add(8'hC3, 8'h3D, 1'b1);

    // R6: results held while idle
    last = {cout_m, sum_m};
    repeat (6) @(negedge clk);
    chk(done_m && done_o, "R6 done held", {done_m, done_o}, 2'b11);
    chk({cout_m, sum_m} == last, "R6 mealy result frozen", {cout_m, sum_m}, last);
    chk({cout_o, sum_o} == last, "R6 moore result frozen", {cout_o, sum_o}, last);

    // R1: carry cleared on accept (previous run ended with carry 0/1)
    run_add(8'hFF, 8'hFF, 1'b0);
    run_add(8'h00, 8'h01, 1'b0);

    // R3: carry propagation alternating keep/set/clear
    run_add(8'h01, 8'h01, 1'b0);
    run_add(8'h81, 8'h7F, 1'b0);

    summary();
  end

endmodule